// File: doc/BRIEF.md
# Service Indicator and Identification Request Controller

This block serves the service indicator and service button of a control-network node. A 2-bit configuration code from the node's management logic selects one of four LED drive modes. The LED is dark when the node is fully configured. It blinks slowly at 1/2 Hz while the node has no network address yet. It carries a fast square wave that makes it look dim when no application is loaded. It stays lit when the code is undefined, which signals a fault. Writing an address into an unconfigured node changes its code to the configured value, and the LED goes dark one cycle later.

The service button is active low. It is synchronised and debounced. Each debounced press raises a request to send an identification message, which carries the node's fixed 48-bit unique ID. The request stays up until the transmitter signals that it is ready. The ID is a build-time parameter. Message framing and the line transceiver sit outside this block.

Two state machines do the work. The LED mode machine has the states LED_OFF, LED_BLINK, LED_DIM and LED_STEADY. Each clock it loads the mode that the configuration code selects; a move into another mode restarts the waveform in its lit half. The request machine has the states REQ_IDLE and REQ_PEND. It moves IDLE→PEND on a debounced press and PEND→IDLE when the request is accepted.

Top module: `svc_pin_ctrl`

## Requirements
- R1: Configuration code 2'b00 (configured) drives `led_o` low from the first clock edge after the code is applied.
- R2: Code 2'b01 (unconfigured) blinks `led_o`. After the first edge with the new code, the LED is high for CLK_HZ*1000/(2*BLINK_MILLIHZ) cycles, then low for the same count, and repeats (1/2 Hz by default).
- R3: Code 2'b10 (no application) drives `led_o` as a square wave. After the first edge with the new code, it is high for CLK_HZ/(2*DIM_HZ) cycles, then low for the same count (76 kHz by default). Any change of code restarts the waveform in its high half.
- R4: Code 2'b11 (undefined) holds `led_o` high from the first edge after it is applied.
- R5: When `svc_n_i` falls and stays low, `svc_req_o` rises on the DEB_CYCLES+2nd clock edge, counting from the first edge that samples the low level. A low pulse shorter than DEB_CYCLES cycles raises no request.
- R6: Releasing the button (a debounced rise of `svc_n_i`) raises no request.
- R7: `svc_req_o` stays high while `tx_ready_i` is low. It falls on the first edge at which both are high.
- R8: A press that completes while a request is pending is dropped, not queued.
- R9: `node_id_o` equals the NODE_ID parameter while `svc_req_o` is high and is zero otherwise.
- R10: While `rst_i` is high, `led_o` is low, `svc_req_o` is low and `node_id_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cfg_state_i | input | 2 | Node configuration code |
| svc_n_i | input | 1 | Service button, active low, asynchronous |
| tx_ready_i | input | 1 | Transmitter accepts the pending request |
| led_o | output | 1 | Service LED drive |
| svc_req_o | output | 1 | Identification message request |
| node_id_o | output | 48 | Unique ID presented with the request |

## Verification
An LED result is due one edge after a code change, because the mode register is the only register on that path. The bench changes the code at a falling edge and samples at every later falling edge. It compares each sample with the phase computed from the half-period count. A button result is due DEB_CYCLES+2 edges after the input falls: two synchroniser stages and the debounce count. The bench checks that the request is still low one edge before that point and high at it. Acceptance takes effect one edge after `tx_ready_i` is seen with the request high, and the bench samples the falling edge that follows.

// File: rtl/svc_pin_pkg.sv
package svc_pin_pkg;

    // Configuration code values on cfg_state_i.
    localparam logic [1:0] CFG_READY  = 2'b00;
    localparam logic [1:0] CFG_NOADDR = 2'b01;
    localparam logic [1:0] CFG_NOAPP  = 2'b10;
    localparam logic [1:0] CFG_BAD    = 2'b11;

    typedef enum logic [1:0] {
        LED_OFF    = 2'd0,
        LED_BLINK  = 2'd1,
        LED_DIM    = 2'd2,
        LED_STEADY = 2'd3
    } led_mode_e;

    typedef enum logic {
        REQ_IDLE = 1'b0,
        REQ_PEND = 1'b1
    } req_state_e;

endpackage

// File: rtl/svc_led_gen.sv
module svc_led_gen
    import svc_pin_pkg::*;
#(
    parameter int unsigned BLINK_HALF = 10_000_000,
    parameter int unsigned DIM_HALF   = 65
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic [1:0] cfg_i,
    output logic       led_o
);
    localparam int unsigned MAX_HALF = (BLINK_HALF > DIM_HALF) ? BLINK_HALF : DIM_HALF;
    localparam int unsigned CW       = (MAX_HALF > 1) ? $clog2(MAX_HALF) : 1;
    localparam logic [CW-1:0] BLINK_LAST = CW'(BLINK_HALF - 1);
    localparam logic [CW-1:0] DIM_LAST   = CW'(DIM_HALF - 1);

    led_mode_e     mode_q, mode_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_cnt;
    logic          phase_q;

    // Next mode from the configuration code.
    always_comb begin
        unique case (cfg_i)
            CFG_READY:  mode_d = LED_OFF;
            CFG_NOADDR: mode_d = LED_BLINK;
            CFG_NOAPP:  mode_d = LED_DIM;
            default:    mode_d = LED_STEADY;
        endcase
    end

    assign last_cnt = (mode_q == LED_DIM) ? DIM_LAST : BLINK_LAST;

    // State register with the half-period divider.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mode_q  <= LED_OFF;
            cnt_q   <= '0;
            phase_q <= 1'b1;
        end else begin
            mode_q <= mode_d;
            if (mode_d != mode_q) begin
                cnt_q   <= '0;
                phase_q <= 1'b1;
            end else if (mode_q == LED_BLINK || mode_q == LED_DIM) begin
                if (cnt_q == last_cnt) begin
                    cnt_q   <= '0;
                    phase_q <= ~phase_q;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // Output decode.
    always_comb begin
        unique case (mode_q)
            LED_OFF:    led_o = 1'b0;
            LED_BLINK:  led_o = phase_q;
            LED_DIM:    led_o = phase_q;
            LED_STEADY: led_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/svc_btn_filter.sv
module svc_btn_filter #(
    parameter int unsigned DEB_CYCLES = 200_000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic btn_n_i,
    output logic press_o
);
    localparam int unsigned DW = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;
    localparam logic [DW-1:0] DEB_LAST = DW'(DEB_CYCLES - 1);

    logic          meta_q, sync_q, filt_q;
    logic [DW-1:0] cnt_q;
    logic          settle;

    assign settle  = (sync_q != filt_q) && (cnt_q == DEB_LAST);
    assign press_o = settle && filt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            filt_q <= 1'b1;
            cnt_q  <= '0;
        end else begin
            meta_q <= btn_n_i;
            sync_q <= meta_q;
            if (sync_q == filt_q) begin
                cnt_q <= '0;
            end else if (settle) begin
                cnt_q  <= '0;
                filt_q <= sync_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/svc_req_fsm.sv
module svc_req_fsm
    import svc_pin_pkg::*;
#(
    parameter int unsigned      ID_W    = 48,
    parameter logic [ID_W-1:0]  NODE_ID = '0
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            press_i,
    input  logic            tx_ready_i,
    output logic            req_o,
    output logic [ID_W-1:0] id_o
);
    req_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE: if (press_i)    state_d = REQ_PEND;
            REQ_PEND: if (tx_ready_i) state_d = REQ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= REQ_IDLE;
        else       state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            REQ_IDLE: begin
                req_o = 1'b0;
                id_o  = '0;
            end
            REQ_PEND: begin
                req_o = 1'b1;
                id_o  = NODE_ID;
            end
        endcase
    end

endmodule

// File: rtl/svc_pin_ctrl.sv
module svc_pin_ctrl #(
    parameter int unsigned     CLK_HZ        = 10_000_000,
    parameter int unsigned     DIM_HZ        = 76_000,
    parameter int unsigned     BLINK_MILLIHZ = 500,
    parameter int unsigned     DEB_CYCLES    = 200_000,
    parameter int unsigned     ID_W          = 48,
    parameter logic [ID_W-1:0] NODE_ID       = 48'h5A3C_9E01_D4B7
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [1:0]      cfg_state_i,
    input  logic            svc_n_i,
    input  logic            tx_ready_i,
    output logic            led_o,
    output logic            svc_req_o,
    output logic [ID_W-1:0] node_id_o
);
    localparam longint unsigned BLINK_HALF_L =
        (longint'(CLK_HZ) * 1000) / (2 * longint'(BLINK_MILLIHZ));
    localparam int unsigned BLINK_HALF = int'(BLINK_HALF_L);
    localparam int unsigned DIM_HALF   = CLK_HZ / (2 * DIM_HZ);

    logic press;

    svc_led_gen #(
        .BLINK_HALF(BLINK_HALF),
        .DIM_HALF  (DIM_HALF)
    ) u_led (
        .clk_i(clk_i),
        .rst_i(rst_i),
        .cfg_i(cfg_state_i),
        .led_o(led_o)
    );

    svc_btn_filter #(
        .DEB_CYCLES(DEB_CYCLES)
    ) u_btn (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .btn_n_i(svc_n_i),
        .press_o(press)
    );

    svc_req_fsm #(
        .ID_W   (ID_W),
        .NODE_ID(NODE_ID)
    ) u_req (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .press_i   (press),
        .tx_ready_i(tx_ready_i),
        .req_o     (svc_req_o),
        .id_o      (node_id_o)
    );

endmodule

// File: rtl/svc_pin_ctrl_chk.sv
module svc_pin_ctrl_chk #(
    parameter int unsigned     ID_W    = 48,
    parameter logic [ID_W-1:0] NODE_ID = '0
) (
    input logic            clk_i,
    input logic            rst_i,
    input logic [1:0]      cfg_state_i,
    input logic            tx_ready_i,
    input logic            led_o,
    input logic            svc_req_o,
    input logic [ID_W-1:0] node_id_o
);
    assert_led_dark_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg_state_i == 2'b00) |=> !led_o);

    assert_led_fault_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg_state_i == 2'b11) |=> led_o);

    assert_req_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (svc_req_o && !tx_ready_i) |=> svc_req_o);

    assert_req_drop_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (svc_req_o && tx_ready_i) |=> !svc_req_o);

    assert_id_with_req_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        svc_req_o |-> (node_id_o == NODE_ID));

    assert_id_idle_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !svc_req_o |-> (node_id_o == '0));

endmodule

bind svc_pin_ctrl svc_pin_ctrl_chk #(
    .ID_W   (ID_W),
    .NODE_ID(NODE_ID)
) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .cfg_state_i(cfg_state_i),
    .tx_ready_i (tx_ready_i),
    .led_o      (led_o),
    .svc_req_o  (svc_req_o),
    .node_id_o  (node_id_o)
);

// File: tb/svc_pin_ctrl_bench.sv
module svc_pin_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int unsigned CLK_HZ = 1520;
    localparam int unsigned DIM_HZ = 76;
    localparam int unsigned BLINK_MHZ = 500;
    localparam int unsigned DEB = 4;
    localparam logic [47:0] ID = 48'hA5C3_0F1E_7B29;
    localparam int BLINK_HALF = (CLK_HZ * 1000) / (2 * BLINK_MHZ);
    localparam int DIM_HALF = CLK_HZ / (2 * DIM_HZ);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg = 2'b00;
    logic        svc_n = 1'b1;
    logic        tx_ready = 1'b0;
    logic        led, req;
    logic [47:0] id;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    svc_pin_ctrl #(
        .CLK_HZ       (CLK_HZ),
        .DIM_HZ       (DIM_HZ),
        .BLINK_MILLIHZ(BLINK_MHZ),
        .DEB_CYCLES   (DEB),
        .ID_W         (48),
        .NODE_ID      (ID)
    ) u_svc_pin_ctrl (
        .clk_i      (clk),
        .rst_i      (rst),
        .cfg_state_i(cfg),
        .svc_n_i    (svc_n),
        .tx_ready_i (tx_ready),
        .led_o      (led),
        .svc_req_o  (req),
        .node_id_o  (id)
    );

    task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_req(input string tag, input logic exp);
        chk(tag, {47'd0, req}, {47'd0, exp});
        chk({tag, " id R9"}, id, exp ? ID : 48'd0);
    endtask

    // Apply a code and compare the LED for n samples against the computed pattern.
    task automatic led_sweep(input logic [1:0] code, input int n, input string tag);
        @(negedge clk);
        cfg = code;
        for (int k = 0; k < n; k++) begin
            logic e;
            @(negedge clk);
            unique case (code)
                2'b00: e = 1'b0;
                2'b01: e = ((k / BLINK_HALF) % 2) == 0;
                2'b10: e = ((k / DIM_HALF) % 2) == 0;
                default: e = 1'b1;
            endcase
            chk(tag, {47'd0, led}, {47'd0, e});
        end
    endtask

    task automatic idle_req(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk_req(tag, 1'b0);
        end
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R10: reset state.
        repeat (3) @(negedge clk);
        chk("R10 led", {47'd0, led}, 48'd0);
        chk_req("R10 req", 1'b0);
        rst = 1'b0;

        // LED sweeps over all codes, including restarts between toggling modes.
        led_sweep(2'b00, 20, "R1 dark");
        led_sweep(2'b01, 4 * BLINK_HALF, "R2 blink");
        led_sweep(2'b10, 6 * DIM_HALF, "R3 dim");
        led_sweep(2'b01, 3 * DIM_HALF, "R3 restart to blink");
        led_sweep(2'b10, 3 * DIM_HALF + 3, "R3 restart to dim");
        led_sweep(2'b11, 20, "R4 fault");
        led_sweep(2'b00, 20, "R1 dark again");

        // R5: short glitch gives no request.
        @(negedge clk);
        svc_n = 1'b0;
        repeat (DEB - 1) @(negedge clk);
        svc_n = 1'b1;
        idle_req(2 * DEB + 4, "R5 glitch");

        // R5: held press raises the request on edge DEB+2.
        svc_n = 1'b0;
        repeat (DEB + 1) @(negedge clk);
        chk_req("R5 before due", 1'b0);
        @(negedge clk);
        chk_req("R5 due", 1'b1);

        // R7: held while transmitter not ready.
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk_req("R7 hold", 1'b1);
        end

        // R6: release while pending, then R8 new press while pending.
        svc_n = 1'b1;
        for (int k = 0; k < DEB + 4; k++) begin
            @(negedge clk);
            chk_req("R6 release pending", 1'b1);
        end
        svc_n = 1'b0;
        for (int k = 0; k < DEB + 4; k++) begin
            @(negedge clk);
            chk_req("R8 press pending", 1'b1);
        end

        // R7: accept.
        tx_ready = 1'b1;
        @(negedge clk);
        chk_req("R7 accepted", 1'b0);
        tx_ready = 1'b0;
        idle_req(DEB + 6, "R8 not queued");

        // R6: release from idle gives no request.
        svc_n = 1'b1;
        idle_req(DEB + 6, "R6 release idle");

        // R5/R7: press with transmitter already ready: one-cycle request.
        tx_ready = 1'b1;
        svc_n = 1'b0;
        repeat (DEB + 1) @(negedge clk);
        chk_req("R5 second before due", 1'b0);
        @(negedge clk);
        chk_req("R5 second due", 1'b1);
        @(negedge clk);
        chk_req("R7 immediate accept", 1'b0);
        idle_req(DEB + 4, "R8 held after accept");
        tx_ready = 1'b0;
        svc_n = 1'b1;
        idle_req(DEB + 4, "R6 final release");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule